// File: doc/BRIEF.md
# SPI NAND Page-Program and Block-Erase Sequencer

This block runs one complete erase or program operation on a serial NAND memory over a four-wire SPI link. A host raises a one-cycle start together with an operation select, a row address and a column address. The sequencer then sends the whole chain of SPI frames on its own: it sets the write latch, sends either the block-erase command or the cache-load command with a full page of data followed by the program-execute command, and then polls the status feature register until the memory stops reporting "in progress". The bit-level SPI engine (mode 0, MSB first, SCK derived from the system clock by a parameter) sits inside the block.

A poll loop is bounded. Status is read at once after the array command, then after a programmable wait, up to a programmable number of reads. If the memory never leaves the busy state, or if it reports the failure bit that belongs to the running operation, the sequencer first clears the write latch and then reports the outcome. Each operation ends with exactly one single-cycle result pulse: done, timeout, erase failure or program failure. Page data is pulled from the host one byte at a time through a take strobe, so no buffer is held inside. Multi-page transfers and bad-block handling are left to the host, which calls the block again for each page or block.

Top module: `nand_pe_seq`

## Requirements
- R1: Out of reset busy_o is 0, spi_cs_n_o is 1, spi_sck_o is 0 and all four result pulses are 0.
- R2: An erase (op_erase_i = 1) sends the one-byte frame 0x06, then the frame 0xD8 followed by the row in three bytes, most significant first, with the low 6 row bits forced to 0 (the row of page 0 in a 64-page block), then status frames; a successful erase ends with done_o and no further frame.
- R3: A program (op_erase_i = 0) sends 0x06, then 0x84 followed by the column in two bytes (high first) and PAGE_BYTES data bytes, then 0x10 followed by the unmodified row in three bytes, then status frames; each data byte is the value on wr_data_i in the cycle data_take_o is high, and data_take_o is high exactly PAGE_BYTES times.
- R4: A status frame is the three bytes 0x0F, 0xC0, 0x00; the status byte is the MISO value during the third byte, MSB first; status bit 0 set means the memory is still busy.
- R5: After a busy status the next status frame begins no sooner than POLL_WAIT clocks later; after POLL_MAX busy status frames the block sends 0x04 and pulses timeout_o.
- R6: In an erase, a ready status with bit 2 set leads to the frame 0x04 and erase_fail_o; bit 3 has no effect in an erase.
- R7: In a program, a ready status with bit 3 set leads to the frame 0x04 and prog_fail_o; bit 2 has no effect in a program.
- R8: A program whose column is not a multiple of PAGE_BYTES sends no frame and no data_take_o; prog_fail_o pulses in the cycle after start, with busy_o high in that cycle only.
- R9: busy_o rises in the cycle after an accepted start; exactly one result pulse appears, in the last cycle busy_o is high.
- R10: start_i while busy_o is high is ignored: the running operation and its frames are unchanged.
- R11: spi_cs_n_o stays high at least GAP_CYC (at least 2) clocks between frames; SCK idles low, MOSI changes only while SCK is low and MISO is sampled on the SCK rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_erase_i | input | 1 | 1 selects block erase, 0 selects page program |
| row_i | input | 24 | Row (page) address |
| col_i | input | 16 | Column address for the cache load |
| wr_data_i | input | 8 | Current page data byte from the host |
| data_take_o | output | 1 | The byte on wr_data_i is consumed this cycle |
| spi_sck_o | output | 1 | SPI clock, idle low |
| spi_cs_n_o | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data to the memory |
| spi_miso_i | input | 1 | SPI data from the memory |
| busy_o | output | 1 | An operation is running |
| done_o | output | 1 | Pulse: operation finished without error |
| timeout_o | output | 1 | Pulse: memory still busy after the last poll |
| erase_fail_o | output | 1 | Pulse: memory reported an erase failure |
| prog_fail_o | output | 1 | Pulse: program failed or column misaligned |

## Verification
A wrong frame pointer or byte index shows at the SPI pins within one frame as a missing, extra or reordered byte, which the bench rebuilds from SCK and MOSI and compares with the byte lists of R2, R3 and R4. A poll counter or wait timer that misbehaves shows as the wrong number of status frames or a too-short chip-select gap before the next poll, visible as soon as the second poll starts. A wrong decode of the captured status shows in the result pulse at the end of the same operation, and a missing write-latch clear shows as a missing final 0x04 frame.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] OPC_WEN    = 8'h06;
  localparam logic [7:0] OPC_WDIS   = 8'h04;
  localparam logic [7:0] OPC_ERASE  = 8'hD8;
  localparam logic [7:0] OPC_LOAD   = 8'h84;
  localparam logic [7:0] OPC_EXEC   = 8'h10;
  localparam logic [7:0] OPC_GETF   = 8'h0F;
  localparam logic [7:0] FEAT_STAT  = 8'hC0;

  typedef enum logic [2:0] {
    F_WEN, F_ERASE, F_LOAD, F_EXEC, F_STAT, F_WDIS
  } frame_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_SHIFT, S_GAP, S_WAIT, S_FIN
  } state_e;

  typedef enum logic [1:0] {
    RES_DONE, RES_TMO, RES_EFAIL, RES_PFAIL
  } result_e;

  // number of bytes in a frame of the given kind
  function automatic int frame_len(frame_e k, int page_bytes);
    case (k)
      F_WEN, F_WDIS:    return 1;
      F_ERASE, F_EXEC:  return 4;
      F_LOAD:           return 3 + page_bytes;
      default:          return 3;
    endcase
  endfunction

  // first page of the block that holds the row
  function automatic logic [23:0] block_row(logic [23:0] row);
    return {row[23:6], 6'd0};
  endfunction

  function automatic logic col_aligned(logic [15:0] col, int page_bytes);
    return (int'(col) % page_bytes) == 0;
  endfunction

  function automatic logic stat_busy(logic [7:0] s);
    return s[0];
  endfunction

  function automatic logic stat_efail(logic [7:0] s);
    return s[2];
  endfunction

  function automatic logic stat_pfail(logic [7:0] s);
    return s[3];
  endfunction

  // byte i of a frame; i >= 3 of a cache load comes from the host
  function automatic logic [7:0] frame_byte(frame_e k, int i, logic [23:0] row,
                                            logic [15:0] col, logic [7:0] data);
    logic [23:0] r;
    r = (k == F_ERASE) ? block_row(row) : row;
    case (k)
      F_WEN:  return OPC_WEN;
      F_WDIS: return OPC_WDIS;
      F_ERASE, F_EXEC: begin
        case (i)
          0:       return (k == F_ERASE) ? OPC_ERASE : OPC_EXEC;
          1:       return r[23:16];
          2:       return r[15:8];
          default: return r[7:0];
        endcase
      end
      F_LOAD: begin
        case (i)
          0:       return OPC_LOAD;
          1:       return col[15:8];
          2:       return col[7:0];
          default: return data;
        endcase
      end
      default: begin
        case (i)
          0:       return OPC_GETF;
          1:       return FEAT_STAT;
          default: return 8'h00;
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/nand_spi_shift.sv
module nand_spi_shift #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HC_W-1:0] hc;
  logic [2:0]      bitn;
  logic [7:0]      sh;
  logic            act;
  logic            half_end_w;

  assign half_end_w = act && (hc == HC_W'(HALF - 1));
  assign mosi_o     = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0; bitn <= '0; sh <= '0; act <= 1'b0;
      sck_o <= 1'b0; done_o <= 1'b0; rx_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !act) begin
        sh <= tx_i; act <= 1'b1; hc <= '0; bitn <= '0; sck_o <= 1'b0;
      end else if (act) begin
        hc <= half_end_w ? '0 : hc + 1'b1;
        if (half_end_w) begin
          if (!sck_o) begin
            sck_o <= 1'b1;
            rx_o  <= {rx_o[6:0], miso_i};
          end else begin
            sck_o <= 1'b0;
            if (bitn == 3'd7) begin
              act <= 1'b0; done_o <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end

  a_r11_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> $stable(mosi_o));
  a_r11_done_low: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sck_o);
endmodule

// File: rtl/nand_poll_ctrl.sv
module nand_poll_ctrl #(
  parameter int POLL_MAX  = 200,
  parameter int POLL_WAIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic hit_i,
  input  logic wait_go_i,
  output logic last_o,
  output logic wait_done_o
);
  localparam int ATT_W = $clog2(POLL_MAX + 1);
  localparam int WT_W  = $clog2(POLL_WAIT + 1);

  logic [ATT_W-1:0] att;
  logic [WT_W-1:0]  wt;
  logic             waiting;

  assign last_o      = (att == ATT_W'(POLL_MAX - 1));
  assign wait_done_o = waiting && (wt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att <= '0; wt <= '0; waiting <= 1'b0;
    end else begin
      if (clr_i)      att <= '0;
      else if (hit_i) att <= att + 1'b1;
      if (wait_go_i) begin
        wt <= WT_W'(POLL_WAIT - 1); waiting <= 1'b1;
      end else if (wait_done_o) begin
        waiting <= 1'b0;
      end else if (waiting) begin
        wt <= wt - 1'b1;
      end
    end
  end

  a_r5_att_bound: assert property (@(posedge clk) disable iff (!rst_n)
    att <= ATT_W'(POLL_MAX));
  a_r5_no_hit_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !hit_i);
endmodule

// File: rtl/nand_pe_seq.sv
module nand_pe_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int SCK_DIV    = 4,
  parameter int GAP_CYC    = 2,
  parameter int POLL_MAX   = 200,
  parameter int POLL_WAIT  = 10000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        op_erase_i,
  input  logic [23:0] row_i,
  input  logic [15:0] col_i,
  input  logic [7:0]  wr_data_i,
  output logic        data_take_o,
  output logic        spi_sck_o,
  output logic        spi_cs_n_o,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        timeout_o,
  output logic        erase_fail_o,
  output logic        prog_fail_o
);
  localparam int IDX_W = $clog2(PAGE_BYTES + 4);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int HALF  = SCK_DIV / 2;

  state_e           st;
  frame_e           cur;
  result_e          res_q;
  logic [IDX_W-1:0] idx;
  logic [GAP_W-1:0] gcnt;
  logic             erase_q;
  logic [23:0]      row_q;
  logic [15:0]      col_q;
  logic [7:0]       stat_q;

  // named internal events
  logic       start_ok_w, misalign_w, last_byte_w, frame_end_w, gap_end_w;
  logic       poll_busy_w, poll_last_w, wait_done_w, byte_go_w, sh_done_w;
  logic [7:0] byte_tx_w, sh_rx_w;

  assign start_ok_w  = start_i && (st == S_IDLE);
  assign misalign_w  = !op_erase_i && !col_aligned(col_i, PAGE_BYTES);
  assign last_byte_w = (idx == IDX_W'(frame_len(cur, PAGE_BYTES) - 1));
  assign frame_end_w = (st == S_SHIFT) && sh_done_w && last_byte_w;
  assign gap_end_w   = (st == S_GAP) && (gcnt == GAP_W'(GAP_CYC - 1));
  assign poll_busy_w = gap_end_w && (cur == F_STAT) && stat_busy(stat_q);
  assign byte_go_w   = (st == S_ISSUE);
  assign byte_tx_w   = frame_byte(cur, int'(idx), row_q, col_q, wr_data_i);

  assign data_take_o = byte_go_w && (cur == F_LOAD) && (idx >= IDX_W'(3));
  assign spi_cs_n_o  = !((st == S_ISSUE) || (st == S_SHIFT));
  assign busy_o      = (st != S_IDLE);
  assign done_o       = (st == S_FIN) && (res_q == RES_DONE);
  assign timeout_o    = (st == S_FIN) && (res_q == RES_TMO);
  assign erase_fail_o = (st == S_FIN) && (res_q == RES_EFAIL);
  assign prog_fail_o  = (st == S_FIN) && (res_q == RES_PFAIL);

  nand_spi_shift #(.HALF(HALF)) shift_i (
    .clk(clk), .rst_n(rst_n), .go_i(byte_go_w), .tx_i(byte_tx_w),
    .miso_i(spi_miso_i), .sck_o(spi_sck_o), .mosi_o(spi_mosi_o),
    .done_o(sh_done_w), .rx_o(sh_rx_w)
  );

  nand_poll_ctrl #(.POLL_MAX(POLL_MAX), .POLL_WAIT(POLL_WAIT)) poll_i (
    .clk(clk), .rst_n(rst_n), .clr_i(start_ok_w), .hit_i(poll_busy_w),
    .wait_go_i(poll_busy_w && !poll_last_w), .last_o(poll_last_w),
    .wait_done_o(wait_done_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= F_WEN; res_q <= RES_DONE; idx <= '0; gcnt <= '0;
      erase_q <= 1'b0; row_q <= '0; col_q <= '0; stat_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_ok_w) begin
          erase_q <= op_erase_i; row_q <= row_i; col_q <= col_i;
          cur <= F_WEN; idx <= '0;
          if (misalign_w) begin
            res_q <= RES_PFAIL; st <= S_FIN;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: st <= S_SHIFT;
        S_SHIFT: if (sh_done_w) begin
          if (last_byte_w) begin
            if (cur == F_STAT) stat_q <= sh_rx_w;
            gcnt <= '0; st <= S_GAP;
          end else begin
            idx <= idx + 1'b1; st <= S_ISSUE;
          end
        end
        S_GAP: if (!gap_end_w) begin
          gcnt <= gcnt + 1'b1;
        end else begin
          idx <= '0; st <= S_ISSUE;
          case (cur)
            F_WEN:   cur <= erase_q ? F_ERASE : F_LOAD;
            F_LOAD:  cur <= F_EXEC;
            F_ERASE, F_EXEC: cur <= F_STAT;
            F_STAT: begin
              if (stat_busy(stat_q)) begin
                if (poll_last_w) begin
                  cur <= F_WDIS; res_q <= RES_TMO;
                end else begin
                  st <= S_WAIT;
                end
              end else if (erase_q && stat_efail(stat_q)) begin
                cur <= F_WDIS; res_q <= RES_EFAIL;
              end else if (!erase_q && stat_pfail(stat_q)) begin
                cur <= F_WDIS; res_q <= RES_PFAIL;
              end else begin
                res_q <= RES_DONE; st <= S_FIN;
              end
            end
            default: st <= S_FIN;
          endcase
        end
        S_WAIT: if (wait_done_w) begin
          idx <= '0; st <= S_ISSUE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, timeout_o, erase_fail_o, prog_fail_o}));
  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o || erase_fail_o || prog_fail_o) |=> !busy_o);
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(row_q) && $stable(erase_q)));
  a_r11_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n_o) |=> spi_cs_n_o);
  a_r11_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sck_o);
  a_r3_take_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    data_take_o |-> !erase_q);
endmodule

// File: tb/nand_pe_seq_tb.sv
`timescale 1ns/1ps
module nand_pe_seq_tb_top;
  localparam int PB = 16, PMAX = 8, PWAIT = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0;
  logic [23:0] row = '0;
  logic [15:0] col = '0;
  logic [7:0] wr_data;
  logic take, sck, cs_n, mosi, miso = 1'b0;
  logic busy, done, tmo, efail, pfail;

  always #2.5 clk = ~clk;

  nand_pe_seq #(.PAGE_BYTES(PB), .SCK_DIV(4), .GAP_CYC(2),
                .POLL_MAX(PMAX), .POLL_WAIT(PWAIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_erase_i(op_erase),
    .row_i(row), .col_i(col), .wr_data_i(wr_data), .data_take_o(take),
    .spi_sck_o(sck), .spi_cs_n_o(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .busy_o(busy), .done_o(done), .timeout_o(tmo), .erase_fail_o(efail),
    .prog_fail_o(pfail)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k);
    return 8'hA0 ^ 8'(k * 7);
  endfunction

  // host data stream
  int ntake = 0;
  assign wr_data = pat(ntake);
  always @(posedge clk) if (take) ntake <= ntake + 1;

  // memory model: frame log and status source
  int frm_b [0:63][0:31];
  int frm_len [0:63];
  int gap_rec [0:63];
  int nfr = 0, nbytes = 0, bits = 0, busy_left = 0, mosi_err = 0, npulse = 0;
  int hcnt = 0;
  logic [7:0] fin_stat = 8'h00, cur_byte = 8'h00;
  logic mosi_at_rise = 1'b0;

  always @(negedge cs_n) begin bits = 0; nbytes = 0; end
  always @(posedge sck) if (!cs_n) begin
    mosi_at_rise = mosi;
    cur_byte = {cur_byte[6:0], mosi};
    bits++;
    if (bits % 8 == 0) begin
      if (nbytes < 32) frm_b[nfr][nbytes] = int'(cur_byte);
      nbytes++;
    end
  end
  always @(negedge sck) if (!cs_n) begin
    if (bits >= 16 && bits < 24 && frm_b[nfr][0] == 32'h0F)
      miso = (busy_left > 0) ? ((bits == 23) ? 1'b1 : 1'b0) : fin_stat[23 - bits];
    else
      miso = 1'b0;
  end
  always @(posedge cs_n) begin
    frm_len[nfr] = nbytes;
    if (nbytes > 0 && frm_b[nfr][0] == 32'h0F && busy_left > 0) busy_left--;
    if (nfr < 63) nfr++;
  end
  always @(negedge clk) begin
    if (sck && mosi !== mosi_at_rise) mosi_err++;
    if (done | tmo | efail | pfail) npulse++;
    if (cs_n) hcnt++;
    else if (hcnt != 0) begin gap_rec[nfr] = hcnt; hcnt = 0; end
  end

  task automatic log_clear(input int bl, input logic [7:0] fs);
    @(negedge clk);
    nfr = 0; busy_left = bl; fin_stat = fs; mosi_err = 0; npulse = 0;
    ntake <= 0;
    for (int i = 0; i < 64; i++) begin gap_rec[i] = 0; frm_len[i] = 0; end
  endtask

  // returns {done, timeout, erase_fail, prog_fail}
  task automatic run_op(input bit er, input logic [23:0] r, input logic [15:0] c,
                        input bit mid_start, output logic [3:0] res);
    int cyc;
    res = '0;
    op_erase = er; row = r; col = c; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", int'(busy), 1);
    cyc = 0;
    while (1) begin
      res = {done, tmo, efail, pfail};
      if (res != 0) break;
      if (cyc > 20000) begin
        chk(1'b0, "R9", "watchdog no result", cyc, 0);
        break;
      end
      @(negedge clk);
      cyc++;
      if (mid_start && cyc == 40) begin start = 1'b1; op_erase = !er; row = 24'hFFFFFF; end
      else start = 1'b0;
    end
    @(negedge clk);
    chk(busy === 1'b0, "R9", "busy low after result", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(npulse == 1, "R9", "result pulse count", npulse, 1);
  endtask

  task automatic chk_frame(input int i, input int len, input int b0, input int b1,
                           input int b2, input int b3, input string req);
    chk(frm_len[i] == len, req, $sformatf("frame %0d length", i), frm_len[i], len);
    chk(frm_b[i][0] == b0, req, $sformatf("frame %0d byte0", i), frm_b[i][0], b0);
    if (len > 1) chk(frm_b[i][1] == b1, req, $sformatf("frame %0d byte1", i), frm_b[i][1], b1);
    if (len > 2) chk(frm_b[i][2] == b2, req, $sformatf("frame %0d byte2", i), frm_b[i][2], b2);
    if (len > 3) chk(frm_b[i][3] == b3, req, $sformatf("frame %0d byte3", i), frm_b[i][3], b3);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy === 1'b0, "R1", "busy at reset", int'(busy), 0);
    chk(cs_n === 1'b1, "R1", "cs_n at reset", int'(cs_n), 1);
    chk(sck === 1'b0, "R1", "sck at reset", int'(sck), 0);
    chk({done, tmo, efail, pfail} === 4'b0, "R1", "pulses at reset",
        int'({done, tmo, efail, pfail}), 0);
  endtask

  task automatic t_erase_ok;
    logic [3:0] res;
    log_clear(2, 8'h00);
    run_op(1'b1, 24'h012345, 16'h0000, 1'b0, res);
    chk(res == 4'b1000, "R2", "erase result", res, 4'b1000);
    chk(nfr == 5, "R2", "erase frame count", nfr, 5);
    chk_frame(0, 1, 8'h06, 0, 0, 0, "R2");
    chk_frame(1, 4, 8'hD8, 8'h01, 8'h23, 8'h40, "R2");
    for (int i = 2; i < 5; i++) chk_frame(i, 3, 8'h0F, 8'hC0, 8'h00, 0, "R4");
    chk(gap_rec[3] >= PWAIT, "R5", "poll interval 1", gap_rec[3], PWAIT);
    chk(gap_rec[4] >= PWAIT, "R5", "poll interval 2", gap_rec[4], PWAIT);
    chk(gap_rec[1] >= 2 && gap_rec[2] >= 2, "R11", "cs gap", gap_rec[2], 2);
    chk(mosi_err == 0, "R11", "mosi moved while sck high", mosi_err, 0);
  endtask

  task automatic t_erase_fail;
    logic [3:0] res;
    log_clear(0, 8'h04);
    run_op(1'b1, 24'h000080, 16'h0000, 1'b0, res);
    chk(res == 4'b0010, "R6", "erase fail result", res, 4'b0010);
    chk(nfr == 4, "R6", "erase fail frame count", nfr, 4);
    chk_frame(3, 1, 8'h04, 0, 0, 0, "R6");
    log_clear(0, 8'h08);
    run_op(1'b1, 24'h000080, 16'h0000, 1'b0, res);
    chk(res == 4'b1000, "R6", "program bit ignored in erase", res, 4'b1000);
    chk(nfr == 3, "R6", "no disable frame", nfr, 3);
  endtask

  task automatic t_prog_ok;
    logic [3:0] res;
    log_clear(1, 8'h00);
    run_op(1'b0, 24'h0ABCDE, 16'h0020, 1'b0, res);
    chk(res == 4'b1000, "R3", "program result", res, 4'b1000);
    chk(nfr == 5, "R3", "program frame count", nfr, 5);
    chk_frame(0, 1, 8'h06, 0, 0, 0, "R3");
    chk_frame(1, 3 + PB, 8'h84, 8'h00, 8'h20, int'(pat(0)), "R3");
    for (int j = 0; j < PB; j++)
      chk(frm_b[1][3 + j] == int'(pat(j)), "R3", $sformatf("data byte %0d", j),
          frm_b[1][3 + j], int'(pat(j)));
    chk(ntake == PB, "R3", "take count", ntake, PB);
    chk_frame(2, 4, 8'h10, 8'h0A, 8'hBC, 8'hDE, "R3");
    chk_frame(4, 3, 8'h0F, 8'hC0, 8'h00, 0, "R4");
    chk(mosi_err == 0, "R11", "mosi moved while sck high", mosi_err, 0);
  endtask

  task automatic t_prog_fail;
    logic [3:0] res;
    log_clear(0, 8'h08);
    run_op(1'b0, 24'h000100, 16'h0000, 1'b0, res);
    chk(res == 4'b0001, "R7", "program fail result", res, 4'b0001);
    chk(nfr == 5, "R7", "program fail frame count", nfr, 5);
    chk_frame(4, 1, 8'h04, 0, 0, 0, "R7");
    log_clear(0, 8'h04);
    run_op(1'b0, 24'h000100, 16'h0000, 1'b0, res);
    chk(res == 4'b1000, "R7", "erase bit ignored in program", res, 4'b1000);
    chk(nfr == 4, "R7", "no disable frame", nfr, 4);
  endtask

  task automatic t_timeout;
    logic [3:0] res;
    int ns;
    log_clear(1000, 8'h00);
    run_op(1'b1, 24'h000040, 16'h0000, 1'b0, res);
    chk(res == 4'b0100, "R5", "timeout result", res, 4'b0100);
    ns = 0;
    for (int i = 0; i < nfr; i++) if (frm_b[i][0] == 32'h0F) ns++;
    chk(ns == PMAX, "R5", "status frames before timeout", ns, PMAX);
    chk(nfr == PMAX + 3, "R5", "timeout frame count", nfr, PMAX + 3);
    chk_frame(nfr - 1, 1, 8'h04, 0, 0, 0, "R5");
  endtask

  task automatic t_misalign;
    log_clear(0, 8'h00);
    op_erase = 1'b0; col = 16'h0005; row = 24'h000200; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1 && pfail === 1'b1, "R8", "reject pulse with busy",
        int'({busy, pfail}), 3);
    @(negedge clk);
    chk(busy === 1'b0, "R8", "busy after reject", int'(busy), 0);
    repeat (20) @(negedge clk);
    chk(nfr == 0, "R8", "no frame on reject", nfr, 0);
    chk(ntake == 0, "R8", "no take on reject", ntake, 0);
    chk(npulse == 1, "R8", "one reject pulse", npulse, 1);
  endtask

  task automatic t_busy_start;
    logic [3:0] res;
    log_clear(0, 8'h00);
    run_op(1'b1, 24'h0000C0, 16'h0000, 1'b1, res);
    chk(res == 4'b1000, "R10", "result with start while busy", res, 4'b1000);
    chk(nfr == 3, "R10", "frame count unchanged", nfr, 3);
    chk_frame(1, 4, 8'hD8, 8'h00, 8'h00, 8'hC0, "R10");
    chk(ntake == 0, "R10", "no data taken", ntake, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_erase_ok();
    t_erase_fail();
    t_prog_ok();
    t_prog_fail();
    t_timeout();
    t_misalign();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R9 watchdog expired actual=0x1 expected=0x0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule